// File: doc/BRIEF.md
# Clause-Driven Binomial Coefficient Engine

This block computes the binomial coefficient C(n,k) for two small unsigned operands that arrive packed in one input word. The work is a short ordered list of guarded clauses run against one shared data register. Each clause has a guard, and only the first true guard's action runs. One clause rejects k greater than n. One returns 1 at once when k is 0 or k equals n. One ends the run when the running index c has passed k. The last clause is always true: it sends D*(n-c+1) and c to a restoring divider sub-module. When the quotient comes back, it becomes the new D and c moves up by one.

A parameter picks how the clauses are tested. In parallel mode every guard is evaluated in the same cycle and a priority encoder picks the action. In sequential mode a clause pointer tests one guard per cycle. The pointer steps forward on a false guard and goes back to the first clause after an action runs. Both modes give the same result, and they differ only in cycle count.

The upstream side starts a run with a one-cycle start pulse and sees a busy flag while the engine works. The downstream side gets a one-cycle output pulse with the result. While the downstream busy input is high, the engine holds completion back.

Top module: `binom_engine`

## Requirements
- R1: After reset, in_busy is 0, out_start is 0 and result is 0.
- R2: A start pulse while in_busy is 0 loads n from in_word[2*NW-1:NW] and k from in_word[NW-1:0] (bits 15:8 and 7:0 at default widths), and in_busy is 1 from the following cycle until the run completes.
- R3: For k <= n, the result is C(n,k) whenever every intermediate value C(n,c)*c for c <= k fits in DW bits.
- R4: When k > n, the run completes with result 0.
- R5: Guards are ranked in fixed order (k>n, then k==0 or k==n, then c>k, then the divide step), and only the highest-ranked true guard acts. With k==0 or k==n the result is 1 after 1 cycle in parallel mode and after 2 cycles in sequential mode.
- R6: In parallel mode (PARALLEL=1), for 0 < k < n, out_start rises k*(DW+2)+1 clock edges after the start edge.
- R7: In sequential mode (PARALLEL=0), for 0 < k < n, out_start rises k*(DW+5)+3 clock edges after the start edge, which is never fewer than in parallel mode.
- R8: A start pulse while in_busy is 1 is ignored: the running computation's result and latency do not change.
- R9: While out_busy is high at a clock edge, out_start does not rise after that edge. Completion takes place at the first edge where out_busy is low.
- R10: out_start is a one-cycle pulse, and result stays unchanged while the engine is idle.
- R11: The divider is a restoring unit that takes DW cycles per quotient, is never started while busy, and is never given a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_start | input | 1 | Start pulse from upstream |
| in_busy | output | 1 | Engine is computing; starts are ignored |
| in_word | input | 2*NW | Packed operands {n, k} |
| out_start | output | 1 | One-cycle pulse: result is valid |
| out_busy | input | 1 | Downstream cannot take a result yet |
| result | output | DW | Binomial coefficient |

## Verification
The bench builds two instances side by side at the default widths (NW=8, DW=32): one with PARALLEL=1 and one with PARALLEL=0. Both get the same stimulus, so results and exact cycle counts can be compared across modes for every n up to 20 and every k, plus k just above n. Random operands with n up to 30 reach intermediate products near the 32-bit limit. Directed runs hold out_busy past the natural finish and inject a second start mid-run.

// File: rtl/binom_pkg.sv
package binom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_WAITDIV
  } eng_state_e;

  // Clause ranks: lower value wins.
  typedef enum logic [1:0] {
    CL_OVER = 2'd0,
    CL_EDGE = 2'd1,
    CL_DONE = 2'd2,
    CL_STEP = 2'd3
  } clause_e;

  localparam int NCLAUSE = 4;

endpackage

// File: rtl/binom_div.sv
module binom_div #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*W-1:0] din,
  output logic           busy,
  output logic [W-1:0]   quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W:0]    trial;
  logic          step_en;

  assign step_en = (cnt_q != '0);
  assign trial   = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    cnt_d = cnt_q;
    if (start) begin
      rem_d = '0;
      quo_d = din[2*W-1:W];
      dvs_d = din[W-1:0];
      cnt_d = CW'(W);
    end else if (step_en) begin
      if (!trial[W]) begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = {rem_q[W-2:0], quo_q[W-1]};
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = step_en;
  assign quo  = quo_q;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (din[W-1:0] != '0)); // R11
  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R11
  AST_DIV_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == CW'(1)) |=> !busy); // R11

endmodule

// File: rtl/binom_clause_sel.sv
module binom_clause_sel #(
  parameter int NC       = 4,
  parameter bit PARALLEL = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  stall,
  input  logic [NC-1:0]         guards,
  output logic                  fire,
  output logic [$clog2(NC)-1:0] sel
);
  localparam int SW = $clog2(NC);

  generate
    if (PARALLEL) begin : g_par
      always_comb begin
        sel = '0;
        for (int i = NC - 1; i >= 0; i--) begin
          if (guards[i]) sel = SW'(i);
        end
        fire = en && (guards != '0);
      end

      AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ((guards & ((NC'(1) << sel) - NC'(1))) == '0)); // R5
    end else begin : g_seq
      logic [SW-1:0] ptr_q, ptr_d;

      assign sel  = ptr_q;
      assign fire = en && guards[ptr_q];

      always_comb begin
        ptr_d = ptr_q;
        if (!en)                        ptr_d = '0;
        else if (fire && stall)         ptr_d = ptr_q;
        else if (fire)                  ptr_d = '0;
        else if (ptr_q == SW'(NC - 1))  ptr_d = '0;
        else                            ptr_d = ptr_q + SW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
      end

      AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !stall) |=> (ptr_q == '0)); // R5
    end
  endgenerate

  AST_FIRST_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> guards[sel]); // R5
  AST_STALL_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> fire); // R9

endmodule

// File: rtl/binom_engine.sv
module binom_engine #(
  parameter int NW       = 8,
  parameter int DW       = 32,
  parameter bit PARALLEL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_start,
  output logic            in_busy,
  input  logic [2*NW-1:0] in_word,
  output logic            out_start,
  input  logic            out_busy,
  output logic [DW-1:0]   result
);
  import binom_pkg::*;

  localparam int CIW = NW + 1;
  localparam int SW  = $clog2(NCLAUSE);

  eng_state_e      st_q, st_d;
  logic [NW-1:0]   n_q, n_d, k_q, k_d;
  logic [CIW-1:0]  c_q, c_d;
  logic [DW-1:0]   d_q, d_d;
  logic            done_q, done_d;
  logic            ostart_q, ostart_d;

  logic [NCLAUSE-1:0] guards;
  logic               fire, stall, finish;
  logic [SW-1:0]      sel;
  logic               div_start, div_busy;
  logic [DW-1:0]      div_quo, factor, prod;

  assign guards[CL_OVER] = (k_q > n_q);
  assign guards[CL_EDGE] = (k_q == '0) || (k_q == n_q);
  assign guards[CL_DONE] = (c_q > {1'b0, k_q});
  assign guards[CL_STEP] = 1'b1;

  assign finish = fire && (sel != CL_STEP);
  assign stall  = finish && out_busy;

  binom_clause_sel #(.NC(NCLAUSE), .PARALLEL(PARALLEL)) sel_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (st_q == ST_CALC),
    .stall  (stall),
    .guards (guards),
    .fire   (fire),
    .sel    (sel)
  );

  assign factor = DW'(n_q) - DW'(c_q) + DW'(1);
  assign prod   = d_q * factor;

  binom_div #(.W(DW)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .din   ({prod, DW'(c_q)}),
    .busy  (div_busy),
    .quo   (div_quo)
  );

  always_comb begin
    st_d      = st_q;
    n_d       = n_q;
    k_d       = k_q;
    c_d       = c_q;
    d_d       = d_q;
    done_d    = done_q;
    ostart_d  = 1'b0;
    div_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_start) begin
          n_d    = in_word[2*NW-1:NW];
          k_d    = in_word[NW-1:0];
          c_d    = CIW'(1);
          d_d    = DW'(1);
          done_d = 1'b0;
          st_d   = ST_CALC;
        end
      end
      ST_CALC: begin
        if (fire && !stall) begin
          if (sel == CL_STEP) begin
            div_start = 1'b1;
            st_d      = ST_WAITDIV;
          end else begin
            if (sel == CL_OVER) d_d = '0;
            if (sel == CL_EDGE) d_d = DW'(1);
            done_d   = 1'b1;
            ostart_d = 1'b1;
            st_d     = ST_IDLE;
          end
        end
      end
      ST_WAITDIV: begin
        if (!div_busy) begin
          d_d  = div_quo;
          c_d  = c_q + CIW'(1);
          st_d = ST_CALC;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      n_q      <= '0;
      k_q      <= '0;
      c_q      <= '0;
      d_q      <= '0;
      done_q   <= 1'b1;
      ostart_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      n_q      <= n_d;
      k_q      <= k_d;
      c_q      <= c_d;
      d_q      <= d_d;
      done_q   <= done_d;
      ostart_q <= ostart_d;
    end
  end

  assign in_busy   = ~done_q;
  assign out_start = ostart_q;
  assign result    = d_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_start && !in_busy) |=> in_busy); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_start && in_busy) |=> ($stable(n_q) && $stable(k_q))); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_busy |=> !out_start); // R9
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |=> !out_start); // R10
  AST_IDLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_busy |=> (in_busy || $stable(result))); // R10
  AST_DIV_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (st_q == ST_WAITDIV)); // R11

endmodule

// File: tb/binom_engine_tb_top.sv
module binom_engine_tb_top;
  localparam int NW = 8;
  localparam int DW = 32;

  logic            clk;
  logic            rst_n;
  logic            in_start;
  logic [2*NW-1:0] in_word;
  logic            out_busy;
  logic            busy_p, busy_s, ost_p, ost_s;
  logic [DW-1:0]   res_p, res_s;

  int total;
  int bad;

  binom_engine #(.NW(NW), .DW(DW), .PARALLEL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_busy(busy_p),
    .in_word(in_word), .out_start(ost_p), .out_busy(out_busy), .result(res_p)
  );

  binom_engine #(.NW(NW), .DW(DW), .PARALLEL(1'b0)) dut_seq_i (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_busy(busy_s),
    .in_word(in_word), .out_start(ost_s), .out_busy(out_busy), .result(res_s)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint model(input int n, input int k);
    longint r;
    if (k > n) return 0;
    r = 1;
    for (int i = 1; i <= k; i++) r = r * (n - i + 1) / i;
    return r;
  endfunction

  function automatic int exp_lat(input int n, input int k, input bit par);
    if (k > n) return 1;
    if (k == 0 || k == n) return par ? 1 : 2;
    return par ? k * (DW + 2) + 1 : k * (DW + 5) + 3;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // inject_at: cycle at which a stray start is pulsed (0 = none)
  // busy_until: out_busy held high for edges 1..busy_until (0 = never)
  task automatic run_case(input int n, input int k, input int inject_at, input int busy_until);
    int lp, ls, exp_p, exp_s;
    longint rp, rs, er;
    lp = 0; ls = 0; rp = 0; rs = 0;
    @(negedge clk);
    in_word  = {n[NW-1:0], k[NW-1:0]};
    in_start = 1'b1;
    @(negedge clk);
    in_start = 1'b0;
    out_busy = (0 < busy_until);
    check(busy_p && busy_s, "R2 busy after start", {busy_p, busy_s}, 3);
    for (int t = 1; t < 4000 && (lp == 0 || ls == 0); t++) begin
      @(negedge clk);
      if (lp == 0 && ost_p) begin lp = t; rp = res_p; end
      if (ls == 0 && ost_s) begin ls = t; rs = res_s; end
      in_start = (t == inject_at);
      if (t == inject_at) in_word = {8'd20, 8'd10};
      out_busy = (t < busy_until);
    end
    in_start = 1'b0;
    out_busy = 1'b0;
    er = model(n, k);
    exp_p = exp_lat(n, k, 1'b1);
    exp_s = exp_lat(n, k, 1'b0);
    if (busy_until + 1 > exp_p) exp_p = busy_until + 1;
    if (busy_until + 1 > exp_s) exp_s = busy_until + 1;
    if (k > n) begin
      check(rp == er, "R4 parallel result", rp, er);
      check(rs == er, "R4 sequential result", rs, er);
    end else begin
      check(rp == er, "R3 R11 parallel result", rp, er);
      check(rs == er, "R3 R11 sequential result", rs, er);
    end
    if (k == 0 || k == n) begin
      check(lp == exp_p, "R5 parallel latency", lp, exp_p);
      check(ls == exp_s, "R5 sequential latency", ls, exp_s);
    end else begin
      check(lp == exp_p, "R6 parallel latency", lp, exp_p);
      check(ls == exp_s, "R7 sequential latency", ls, exp_s);
    end
    check(lp <= ls, "R7 parallel not slower", lp, ls);
    @(negedge clk);
    check(!ost_p && !ost_s, "R10 pulse width", {ost_p, ost_s}, 0);
    check(res_p == rp && res_s == rs, "R10 idle result", res_p, rp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, k;
    total = 0;
    bad = 0;
    in_start = 1'b0;
    in_word = '0;
    out_busy = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_p && !busy_s, "R1 in_busy", {busy_p, busy_s}, 0);
    check(!ost_p && !ost_s, "R1 out_start", {ost_p, ost_s}, 0);
    check(res_p == 0 && res_s == 0, "R1 result", res_p, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep
    for (int nn = 0; nn <= 20; nn++)
      for (int kk = 0; kk <= nn; kk++) run_case(nn, kk, 0, 0);
    // R4: k just above n
    for (int nn = 0; nn <= 3; nn++) run_case(nn, nn + 1, 0, 0);
    run_case(5, 200, 0, 0);
    // R8: stray start mid-run
    run_case(10, 4, 5, 0);
    run_case(7, 0, 0, 0);
    // R9: downstream busy past natural finish
    run_case(6, 3, 0, 200);
    run_case(9, 9, 0, 10);
    run_case(12, 13, 0, 4);

    // random operands with a fixed seed
    void'($urandom(32'd5813));
    for (int i = 0; i < 24; i++) begin
      n = 21 + int'($urandom_range(9, 0));
      k = int'($urandom_range(n + 2, 0));
      run_case(n, k, 0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule